// File: doc/BRIEF.md
# Power-Management Host Mailbox Channel

This block is a byte-wide mailbox between a host I/O bus and an embedded controller core. It is used to pass power-management commands and data. The host sees two I/O addresses, both taken from configuration inputs: a data port and a command/status port. A host write to either port fills an inbound byte buffer. A host read of the data port returns the outbound byte buffer, which the core fills. A host read of the command/status port returns the shared status byte.

The status byte combines two kinds of bit. Three bits are owned by hardware: outbound-full, inbound-full, and a flag that records whether the last host write was a command or data. The remaining five bits the core writes. It can write them directly at any time. When the enhanced mode bit is set, it can also write them through the channel-control path. The block drives two level-high interrupts to the core, one for outbound empty and one for inbound full. The mode bit chooses where their enables come from: a global control pair in compatible mode, or the channel-control pair in enhanced mode.

All state is held in registers with a synchronous active-high reset. Host read data is returned one cycle after the read strobe, with a valid pulse.

Top module: `pm_mailbox`

## Requirements
- R1: While `rst` is high and on the cycle after it, the status byte reads 0x00, the inbound byte reads 0x00, both interrupts are low and the mode bit is 0. A host data read straight after reset returns 0x00.
- R2: A host write whose address equals `cfg_data_addr` or `cfg_cmd_addr` loads `host_wdata` into the inbound byte and sets inbound-full (status bit 1) from the next cycle. A host write to any other address changes neither.
- R3: Status bit 3 becomes 1 after a host write to the command port and 0 after a host write to the data port.
- R4: A core inbound read (`core_ib_rd`) clears inbound-full on the next cycle. If a matching host write occurs in the same cycle, inbound-full stays set.
- R5: A core outbound write loads the outbound byte and sets outbound-full (status bit 0). A host data-port read returns the outbound byte and clears outbound-full. If a core outbound write occurs in the same cycle as the read, the read returns the old byte and outbound-full stays set.
- R6: A host read of the command port returns the status byte as it stood in the read cycle, pulses `host_rvalid` one cycle later, and leaves outbound-full unchanged.
- R7: A direct core status write (`core_st_wr`) changes only status bits 7, 6, 5, 4 and 2 (mask 0xF4). Bits 0, 1 and 3 keep their hardware values.
- R8: A status write through the channel-control path (`core_ctlst_wr`) takes effect with the same 0xF4 mask only while the mode bit is 1. In mode 0 it is ignored. A direct write in the same cycle takes precedence.
- R9: With the mode bit at 0, `irq_obe` is (not outbound-full) AND `core_gctl_wdata` bit 0 as last written, and `irq_ibf` is inbound-full AND global bit 1. The channel enables have no effect.
- R10: With the mode bit at 1, the enables are channel-control bit 1 (outbound empty) and bit 2 (inbound full), and the global pair has no effect. Channel-control bit 0 is the mode bit.
- R11: Each interrupt is registered. It reflects the status flags and enables one cycle after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_addr | input | AW | Host address of the data port |
| cfg_cmd_addr | input | AW | Host address of the command/status port |
| host_addr | input | AW | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after a matching read |
| core_ib_rd | input | 1 | Core consumes the inbound byte |
| core_ib_data | output | 8 | Inbound byte |
| core_ob_wr | input | 1 | Core writes the outbound byte |
| core_ob_wdata | input | 8 | Outbound byte data |
| core_st_wr | input | 1 | Direct status write |
| core_st_wdata | input | 8 | Direct status data (mask 0xF4) |
| core_ctl_wr | input | 1 | Channel-control write |
| core_ctl_wdata | input | 3 | [0] mode, [1] outbound-empty enable, [2] inbound-full enable |
| core_ctlst_wr | input | 1 | Status write via the channel-control path |
| core_ctlst_wdata | input | 8 | Status data for that path (mask 0xF4) |
| core_gctl_wr | input | 1 | Global control write |
| core_gctl_wdata | input | 2 | [0] outbound-empty enable, [1] inbound-full enable |
| core_status | output | 8 | Status byte |
| irq_obe | output | 1 | Outbound-empty interrupt, level high |
| irq_ibf | output | 1 | Inbound-full interrupt, level high |

## Verification
The hardest situations are the same-cycle collisions. One is a core outbound write meeting a host data read. The other is a core inbound read meeting a host write. In each, the set must win while the read still returns the old byte. The bench drives both strobes in a single cycle from one task. It then reads the data port again, which proves that the new byte was kept. Mode switching is covered by writing all three enable sources to conflicting values. The bench confirms that only the selected pair moves the interrupts, and that in mode 0 the channel-control status path changes nothing.

// File: rtl/pm_mbx_pkg.sv
package pm_mbx_pkg;
  localparam int unsigned BW = 8;
  localparam logic [BW-1:0] CORE_MASK = 8'hF4;
  localparam int unsigned OBF_BIT = 0;
  localparam int unsigned IBF_BIT = 1;
  localparam int unsigned CD_BIT  = 3;

  typedef struct packed {
    logic ibf_ie;
    logic obe_ie;
    logic mode;
  } chan_ctl_t;

  typedef struct packed {
    logic ibf_ie;
    logic obe_ie;
  } glob_ctl_t;
endpackage

// File: rtl/pm_host_decode.sv
module pm_host_decode #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] cfg_data_addr,
  input  logic [AW-1:0] cfg_cmd_addr,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic          data_wr,
  output logic          cmd_wr,
  output logic          data_rd,
  output logic          cmd_rd
);
  logic hit_data, hit_cmd;

  always_comb begin
    hit_data = (host_addr == cfg_data_addr);
    hit_cmd  = (host_addr == cfg_cmd_addr) && !hit_data;
    data_wr  = host_wr && hit_data;
    cmd_wr   = host_wr && hit_cmd;
    data_rd  = host_rd && hit_data;
    cmd_rd   = host_rd && hit_cmd;
  end
endmodule

// File: rtl/pm_buf_regs.sv
module pm_buf_regs
  import pm_mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          data_wr,
  input  logic          cmd_wr,
  input  logic          data_rd,
  input  logic          cmd_rd,
  input  logic [BW-1:0] host_wdata,
  input  logic [BW-1:0] status,
  input  logic          core_ib_rd,
  input  logic          core_ob_wr,
  input  logic [BW-1:0] core_ob_wdata,
  output logic [BW-1:0] ibuf,
  output logic          ibf,
  output logic          obf,
  output logic          cd_flag,
  output logic [BW-1:0] host_rdata,
  output logic          host_rvalid
);
  logic [BW-1:0] obuf;
  logic          any_wr;

  assign any_wr = data_wr || cmd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf    <= '0;
      ibf     <= 1'b0;
      cd_flag <= 1'b0;
    end else begin
      if (any_wr) begin
        ibuf    <= host_wdata;
        cd_flag <= cmd_wr;
      end
      if (any_wr)          ibf <= 1'b1;
      else if (core_ib_rd) ibf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obuf <= '0;
      obf  <= 1'b0;
    end else begin
      if (core_ob_wr)   obuf <= core_ob_wdata;
      if (core_ob_wr)   obf  <= 1'b1;
      else if (data_rd) obf  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= data_rd || cmd_rd;
      if (data_rd)     host_rdata <= obuf;
      else if (cmd_rd) host_rdata <= status;
    end
  end
endmodule

// File: rtl/pm_status_ctl.sv
module pm_status_ctl
  import pm_mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          core_st_wr,
  input  logic [BW-1:0] core_st_wdata,
  input  logic          core_ctl_wr,
  input  chan_ctl_t     core_ctl_wdata,
  input  logic          core_ctlst_wr,
  input  logic [BW-1:0] core_ctlst_wdata,
  input  logic          core_gctl_wr,
  input  glob_ctl_t     core_gctl_wdata,
  output logic [BW-1:0] user_bits,
  output logic          en_obe,
  output logic          en_ibf
);
  chan_ctl_t     chan_q;
  glob_ctl_t     glob_q;
  logic [BW-1:0] user_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      glob_q <= '0;
      user_q <= '0;
    end else begin
      if (core_ctl_wr)  chan_q <= core_ctl_wdata;
      if (core_gctl_wr) glob_q <= core_gctl_wdata;
      if (core_st_wr)
        user_q <= (user_q & ~CORE_MASK) | (core_st_wdata & CORE_MASK);
      else if (core_ctlst_wr && chan_q.mode)
        user_q <= (user_q & ~CORE_MASK) | (core_ctlst_wdata & CORE_MASK);
    end
  end

  always_comb begin
    user_bits = user_q & CORE_MASK;
    if (chan_q.mode) begin
      en_obe = chan_q.obe_ie;
      en_ibf = chan_q.ibf_ie;
    end else begin
      en_obe = glob_q.obe_ie;
      en_ibf = glob_q.ibf_ie;
    end
  end
endmodule

// File: rtl/pm_irq_gate.sv
module pm_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic obf,
  input  logic ibf,
  input  logic en_obe,
  input  logic en_ibf,
  output logic irq_obe,
  output logic irq_ibf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_obe <= 1'b0;
      irq_ibf <= 1'b0;
    end else begin
      irq_obe <= !obf && en_obe;
      irq_ibf <= ibf && en_ibf;
    end
  end
endmodule

// File: rtl/pm_mailbox.sv
module pm_mailbox
  import pm_mbx_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_data_addr,
  input  logic [AW-1:0] cfg_cmd_addr,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          host_rvalid,
  input  logic          core_ib_rd,
  output logic [7:0]    core_ib_data,
  input  logic          core_ob_wr,
  input  logic [7:0]    core_ob_wdata,
  input  logic          core_st_wr,
  input  logic [7:0]    core_st_wdata,
  input  logic          core_ctl_wr,
  input  logic [2:0]    core_ctl_wdata,
  input  logic          core_ctlst_wr,
  input  logic [7:0]    core_ctlst_wdata,
  input  logic          core_gctl_wr,
  input  logic [1:0]    core_gctl_wdata,
  output logic [7:0]    core_status,
  output logic          irq_obe,
  output logic          irq_ibf
);
  logic          data_wr, cmd_wr, data_rd, cmd_rd;
  logic          ibf, obf, cd_flag, en_obe, en_ibf;
  logic [BW-1:0] user_bits, status;

  pm_host_decode #(.AW(AW)) dec_i (
    .cfg_data_addr(cfg_data_addr),
    .cfg_cmd_addr (cfg_cmd_addr),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .data_wr      (data_wr),
    .cmd_wr       (cmd_wr),
    .data_rd      (data_rd),
    .cmd_rd       (cmd_rd)
  );

  always_comb begin
    status          = user_bits;
    status[OBF_BIT] = obf;
    status[IBF_BIT] = ibf;
    status[CD_BIT]  = cd_flag;
  end

  pm_buf_regs buf_i (
    .clk          (clk),
    .rst          (rst),
    .data_wr      (data_wr),
    .cmd_wr       (cmd_wr),
    .data_rd      (data_rd),
    .cmd_rd       (cmd_rd),
    .host_wdata   (host_wdata),
    .status       (status),
    .core_ib_rd   (core_ib_rd),
    .core_ob_wr   (core_ob_wr),
    .core_ob_wdata(core_ob_wdata),
    .ibuf         (core_ib_data),
    .ibf          (ibf),
    .obf          (obf),
    .cd_flag      (cd_flag),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid)
  );

  pm_status_ctl st_i (
    .clk             (clk),
    .rst             (rst),
    .core_st_wr      (core_st_wr),
    .core_st_wdata   (core_st_wdata),
    .core_ctl_wr     (core_ctl_wr),
    .core_ctl_wdata  (chan_ctl_t'(core_ctl_wdata)),
    .core_ctlst_wr   (core_ctlst_wr),
    .core_ctlst_wdata(core_ctlst_wdata),
    .core_gctl_wr    (core_gctl_wr),
    .core_gctl_wdata (glob_ctl_t'(core_gctl_wdata)),
    .user_bits       (user_bits),
    .en_obe          (en_obe),
    .en_ibf          (en_ibf)
  );

  pm_irq_gate irq_i (
    .clk    (clk),
    .rst    (rst),
    .obf    (obf),
    .ibf    (ibf),
    .en_obe (en_obe),
    .en_ibf (en_ibf),
    .irq_obe(irq_obe),
    .irq_ibf(irq_ibf)
  );

  assign core_status = status;
endmodule

// File: rtl/pm_mailbox_chk.sv
module pm_mailbox_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cfg_data_addr,
  input logic [AW-1:0] cfg_cmd_addr,
  input logic [AW-1:0] host_addr,
  input logic          host_wr,
  input logic          host_rd,
  input logic          host_rvalid,
  input logic          core_ib_rd,
  input logic          core_ob_wr,
  input logic          core_st_wr,
  input logic [7:0]    core_status,
  input logic          irq_obe,
  input logic          irq_ibf
);
  logic hit;
  assign hit = (host_addr == cfg_data_addr) || (host_addr == cfg_cmd_addr);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (core_status == 8'h00 && !irq_obe && !irq_ibf)); // R1

  AST_IBF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    host_wr && hit |=> core_status[1]); // R2

  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    core_ib_rd && !host_wr |=> !core_status[1]); // R4

  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    core_ob_wr |=> core_status[0]); // R5

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    host_rd && hit |=> host_rvalid); // R6

  AST_HW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    core_st_wr && !host_wr && !host_rd && !core_ob_wr && !core_ib_rd
    |=> (core_status[1:0] == $past(core_status[1:0]) &&
         core_status[3] == $past(core_status[3]))); // R7

  AST_IRQ_IBF_LAG: assert property (@(posedge clk) disable iff (rst)
    irq_ibf |-> $past(core_status[1])); // R11

  AST_IRQ_OBE_LAG: assert property (@(posedge clk) disable iff (rst)
    irq_obe |-> !$past(core_status[0])); // R11
endmodule

bind pm_mailbox pm_mailbox_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_data_addr(cfg_data_addr),
  .cfg_cmd_addr (cfg_cmd_addr),
  .host_addr    (host_addr),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_rvalid  (host_rvalid),
  .core_ib_rd   (core_ib_rd),
  .core_ob_wr   (core_ob_wr),
  .core_st_wr   (core_st_wr),
  .core_status  (core_status),
  .irq_obe      (irq_obe),
  .irq_ibf      (irq_ibf)
);

// File: tb/pm_mailbox_tb_top.sv
`timescale 1ns/1ps
module pm_mailbox_tb_top;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] DATA_A = 16'h0062;
  localparam logic [AW-1:0] CMD_A  = 16'h0066;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, core_ib_rd = 0, core_ob_wr = 0;
  logic core_st_wr = 0, core_ctl_wr = 0, core_ctlst_wr = 0, core_gctl_wr = 0;
  logic [7:0] host_wdata = 0, core_ob_wdata = 0, core_st_wdata = 0, core_ctlst_wdata = 0;
  logic [2:0] core_ctl_wdata = 0;
  logic [1:0] core_gctl_wdata = 0;
  logic [7:0] host_rdata, core_ib_data, core_status;
  logic host_rvalid, irq_obe, irq_ibf;

  pm_mailbox #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_data_addr(DATA_A), .cfg_cmd_addr(CMD_A),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .core_ib_rd(core_ib_rd), .core_ib_data(core_ib_data),
    .core_ob_wr(core_ob_wr), .core_ob_wdata(core_ob_wdata),
    .core_st_wr(core_st_wr), .core_st_wdata(core_st_wdata),
    .core_ctl_wr(core_ctl_wr), .core_ctl_wdata(core_ctl_wdata),
    .core_ctlst_wr(core_ctlst_wr), .core_ctlst_wdata(core_ctlst_wdata),
    .core_gctl_wr(core_gctl_wr), .core_gctl_wdata(core_gctl_wdata),
    .core_status(core_status), .irq_obe(irq_obe), .irq_ibf(irq_ibf)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the status byte
  logic m_obf = 0, m_ibf = 0, m_cd = 0;
  logic [7:0] m_user = 0;

  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t rd_q[$];

  function automatic logic [7:0] m_status();
    return (m_user & 8'hF4) | {4'b0, m_cd, 1'b0, m_ibf, m_obf};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data on each valid pulse
  always @(posedge clk) begin
    #1;
    if (!rst && host_rvalid) begin
      if (rd_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual unexpected read %02h expected none", host_rdata);
      end else begin
        exp_t e;
        e = rd_q.pop_front();
        check(e.tag, host_rdata, e.val);
      end
    end
  end

  task automatic host_write(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic host_read(logic [AW-1:0] a, logic [7:0] exp, string tag);
    rd_q.push_back('{tag, exp});
    @(negedge clk); host_addr = a; host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 status", core_status, 8'h00);
    check("R1 ibuf", core_ib_data, 8'h00);
    check("R1 irqs", {6'b0, irq_obe, irq_ibf}, 8'h00);
    rst = 0;
    @(negedge clk);
    check("R1 status after release", core_status, 8'h00);
    host_read(DATA_A, 8'h00, "R1 obuf");
    check("R9 no enable no irq", {6'b0, irq_obe, irq_ibf}, 8'h00);

    host_write(DATA_A, 8'h5A); m_ibf = 1; m_cd = 0;
    check("R2 ibuf data", core_ib_data, 8'h5A);
    check("R2 R3 status", core_status, m_status());
    host_write(CMD_A, 8'hC3); m_cd = 1;
    check("R2 ibuf cmd", core_ib_data, 8'hC3);
    check("R3 cmd flag", core_status, m_status());
    host_write(16'h0070, 8'h11);
    check("R2 other addr ignored", core_ib_data, 8'hC3);
    check("R2 other addr status", core_status, m_status());

    @(negedge clk); core_ib_rd = 1;
    @(negedge clk); core_ib_rd = 0; m_ibf = 0;
    check("R4 ibf cleared", core_status, m_status());
    @(negedge clk); core_ib_rd = 1; host_addr = DATA_A; host_wdata = 8'h77; host_wr = 1;
    @(negedge clk); core_ib_rd = 0; host_wr = 0; m_ibf = 1; m_cd = 0;
    check("R4 collision ibf kept", core_status, m_status());
    check("R4 collision data", core_ib_data, 8'h77);

    @(negedge clk); core_ob_wr = 1; core_ob_wdata = 8'h9E;
    @(negedge clk); core_ob_wr = 0; m_obf = 1;
    check("R5 obf set", core_status, m_status());
    host_read(CMD_A, m_status(), "R6 status read");
    check("R6 obf unchanged", core_status, m_status());
    host_read(DATA_A, 8'h9E, "R5 data read"); m_obf = 0;
    check("R5 obf cleared", core_status, m_status());

    @(negedge clk); core_ob_wr = 1; core_ob_wdata = 8'h9E;
    @(negedge clk); core_ob_wr = 0;
    rd_q.push_back('{"R5 collision old byte", 8'h9E});
    @(negedge clk); host_addr = DATA_A; host_rd = 1; core_ob_wr = 1; core_ob_wdata = 8'h44;
    @(negedge clk); host_rd = 0; core_ob_wr = 0; m_obf = 1;
    check("R5 collision obf kept", core_status, m_status());
    host_read(DATA_A, 8'h44, "R5 new byte kept"); m_obf = 0;

    @(negedge clk); core_st_wr = 1; core_st_wdata = 8'hFF;
    @(negedge clk); core_st_wr = 0; m_user = 8'hF4;
    check("R7 masked write", core_status, m_status());
    @(negedge clk); core_st_wr = 1; core_st_wdata = 8'h0B;
    @(negedge clk); core_st_wr = 0; m_user = 8'h00;
    check("R7 hw bits kept", core_status, m_status());

    @(negedge clk); core_ctlst_wr = 1; core_ctlst_wdata = 8'hA4;
    @(negedge clk); core_ctlst_wr = 0;
    check("R8 ignored in mode 0", core_status, m_status());

    // R9: compatible mode, global enables
    @(negedge clk); core_gctl_wr = 1; core_gctl_wdata = 2'b01;
    @(negedge clk); core_gctl_wr = 0;
    @(negedge clk);
    check("R9 obe irq", {6'b0, irq_obe, irq_ibf}, {6'b0, 1'b1, 1'b0});
    @(negedge clk); core_ctl_wr = 1; core_ctl_wdata = 3'b110;
    @(negedge clk); core_ctl_wr = 0;
    @(negedge clk);
    check("R9 channel enables ignored", {6'b0, irq_obe, irq_ibf}, {6'b0, 1'b1, 1'b0});

    // R10: enhanced mode
    @(negedge clk); core_ctl_wr = 1; core_ctl_wdata = 3'b001;
    @(negedge clk); core_ctl_wr = 0;
    @(negedge clk);
    check("R10 global ignored", {6'b0, irq_obe, irq_ibf}, 8'h00);
    @(negedge clk); core_ctlst_wr = 1; core_ctlst_wdata = 8'h50;
    @(negedge clk); core_ctlst_wr = 0; m_user = 8'h50;
    check("R8 enhanced path", core_status, m_status());
    @(negedge clk); core_st_wr = 1; core_st_wdata = 8'h24;
    core_ctlst_wr = 1; core_ctlst_wdata = 8'hC0;
    @(negedge clk); core_st_wr = 0; core_ctlst_wr = 0; m_user = 8'h24;
    check("R8 direct wins", core_status, m_status());

    @(negedge clk); core_ctl_wr = 1; core_ctl_wdata = 3'b101;
    @(negedge clk); core_ctl_wr = 0;
    @(negedge clk);
    check("R10 ibf irq", {6'b0, irq_obe, irq_ibf}, {7'b0, m_ibf});
    @(negedge clk); core_ib_rd = 1;
    @(negedge clk); core_ib_rd = 0; m_ibf = 0;
    @(negedge clk);
    check("R10 ibf irq drops", {6'b0, irq_obe, irq_ibf}, 8'h00);
    host_write(CMD_A, 8'h3C); m_ibf = 1; m_cd = 1;
    check("R11 status leads", core_status, m_status());
    check("R11 irq lags", {7'b0, irq_ibf}, 8'h00);
    @(negedge clk);
    check("R11 irq follows", {7'b0, irq_ibf}, 8'h01);

    @(negedge clk); core_ctl_wr = 1; core_ctl_wdata = 3'b110;
    @(negedge clk); core_ctl_wr = 0;
    @(negedge clk);
    check("R9 back to mode 0", {6'b0, irq_obe, irq_ibf}, {6'b0, 1'b1, 1'b0});

    settle();
    check("R6 all reads returned", 8'(rd_q.size()), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule